// File: doc/BRIEF.md
# Compound Multi-Window Scan Sequencer

This block produces address streams for several rectangular scan windows that travel across a two-dimensional memory together. One loop controller serves all windows. Its inner loop moves every window by that window's own step vector once per cycle, for a programmable number of steps. When an inner pass ends, its outer loop moves the start of the whole inner pattern by a shared shift vector and runs the inner pattern again, for a programmable number of passes. Each window has its own start point, step vector, width, height and a read or write role. The data path that uses the windows sits outside the block.

The block is set up while idle with a single `cfg_load` pulse that captures every configuration bus. A `start` pulse then runs the compound scan. Each cycle with `valid` high carries one (x, y) base address per window. The `stall` input freezes the whole scan for as long as it is held. `done` pulses once when the scan ends. The window count `NUM_WIN` is a parameter from 1 to 8. Addresses are `AW` bits wide, wrap modulo 2^AW, and step and shift values are two's complement.

Top module: `compound_scan_seq`

## Requirements
- R1: After reset `valid`, `busy` and `done` are 0.
- R2: A `start` pulse while idle sets `busy` from the next cycle on, and in that first cycle (if not stalled) every window's output address equals its configured start position. `valid` is never high without `busy`.
- R3: In a valid cycle at inner index i and outer index o, window w outputs x = start_x[w] + o*shift_x + i*step_x[w] and y = start_y[w] + o*shift_y + i*step_y[w], modulo 2^AW.
- R4: An inner pass lasts `cfg_inner_cnt` valid cycles, after which the outer index increases and the inner index returns to 0. A count of 0 acts as 1.
- R5: The scan runs `cfg_outer_cnt` passes (0 acts as 1), giving exactly inner×outer valid cycles per start.
- R6: `done` is high for exactly one cycle, the cycle after the last valid step. In that cycle `busy` and `valid` are 0.
- R7: While `stall` is 1, `valid` is 0, the window addresses hold, and the loop indices do not advance.
- R8: `cfg_load` and `start` are ignored while `busy`. If both arrive in the same idle cycle, the configuration loads and the start is ignored.
- R9: `win_w`, `win_h` and `win_wr` show each window's loaded width, height and role (1 = write target, 0 = read source), and they do not change during a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture all configuration buses (idle only) |
| cfg_start_x | input | NUM_WIN*AW | Per-window start x, window w at [w*AW +: AW] |
| cfg_start_y | input | NUM_WIN*AW | Per-window start y |
| cfg_step_x | input | NUM_WIN*AW | Per-window inner step x, two's complement |
| cfg_step_y | input | NUM_WIN*AW | Per-window inner step y, two's complement |
| cfg_win_w | input | NUM_WIN*SW | Per-window width in words |
| cfg_win_h | input | NUM_WIN*SW | Per-window height in words |
| cfg_win_wr | input | NUM_WIN | Per-window role, 1 = write |
| cfg_inner_cnt | input | CW | Steps per inner pass |
| cfg_outer_cnt | input | CW | Number of outer passes |
| cfg_shift_x | input | AW | Outer shift x, two's complement |
| cfg_shift_y | input | AW | Outer shift y, two's complement |
| start | input | 1 | Begin a scan (idle only) |
| stall | input | 1 | Freeze the scan this cycle |
| win_x | output | NUM_WIN*AW | Per-window base x |
| win_y | output | NUM_WIN*AW | Per-window base y |
| win_w | output | NUM_WIN*SW | Per-window width |
| win_h | output | NUM_WIN*SW | Per-window height |
| win_wr | output | NUM_WIN | Per-window role |
| valid | output | 1 | Addresses are a scan step this cycle |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
Window addresses are built up by adding steps, so one wrong add or a missed inner wrap corrupts every later address of that window. It shows at the ports in the first valid cycle after the fault and stays wrong for the rest of the pass or the whole scan. A loop-index fault shows up as an inner pass of the wrong length, or as `done` arriving early or late against the expected inner×outer count. Random stall patterns check that addresses and indices freeze and resume without losing or repeating a step.

// File: rtl/scan_seq_pkg.sv
// Package: shared types for the compound scan sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package scan_seq_pkg;

    // Largest window count the sequencer is built for.
    localparam int MAX_WINDOWS = 8;

    // Loop controller state.
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/scan_loop_ctrl.sv
// Module: scan_loop_ctrl
// Does: holds the shared inner/outer loop counts and the two loop indices,
//       and issues the step strobes that every window unit follows.
// Assumes: counts of zero behave as one; configuration is taken only while idle,
//          and a start arriving together with a load is ignored.
module scan_loop_ctrl
    import scan_seq_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [CW-1:0] cfg_inner_cnt,
    input  logic [CW-1:0] cfg_outer_cnt,
    input  logic          start,
    input  logic          stall,
    output logic          busy,
    output logic          adv,
    output logic          inner_wrap,
    output logic          restart,
    output logic          cfg_take,
    output logic          done
);

    localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] ZERO = '0;

    seq_state_e    state_q;
    logic [CW-1:0] inner_last_q;
    logic [CW-1:0] outer_last_q;
    logic [CW-1:0] i_q;
    logic [CW-1:0] o_q;
    logic          last_pass;
    logic          done_q;

    assign cfg_take   = (state_q == S_IDLE) && cfg_load;
    assign restart    = (state_q == S_IDLE) && start && !cfg_load;
    assign busy       = (state_q == S_RUN);
    assign adv        = busy && !stall;
    assign inner_wrap = (i_q == inner_last_q);
    assign last_pass  = (o_q == outer_last_q);
    assign done       = done_q;

    // Capture the loop limits as last-index values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inner_last_q <= ZERO;
            outer_last_q <= ZERO;
        end else if (cfg_take) begin
            inner_last_q <= (cfg_inner_cnt == ZERO) ? ZERO : cfg_inner_cnt - ONE;
            outer_last_q <= (cfg_outer_cnt == ZERO) ? ZERO : cfg_outer_cnt - ONE;
        end
    end

    // Step the nested loop indices and the run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            i_q     <= ZERO;
            o_q     <= ZERO;
        end else if (restart) begin
            state_q <= S_RUN;
            i_q     <= ZERO;
            o_q     <= ZERO;
        end else if (adv) begin
            if (inner_wrap) begin
                i_q <= ZERO;
                if (last_pass) begin
                    state_q <= S_IDLE;
                end else begin
                    o_q <= o_q + ONE;
                end
            end else begin
                i_q <= i_q + ONE;
            end
        end
    end

    // Raise the end-of-scan pulse one cycle after the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= adv && inner_wrap && last_pass;
        end
    end

endmodule

// File: rtl/scan_win_unit.sv
// Module: scan_win_unit
// Does: stores one window's placement, step, size and role, and keeps its
//       current base address by adding the step or the outer shift.
// Assumes: the strobes come from scan_loop_ctrl; arithmetic wraps modulo 2^AW.
module scan_win_unit #(
    parameter int AW = 8,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_take,
    input  logic [AW-1:0] cfg_sx,
    input  logic [AW-1:0] cfg_sy,
    input  logic [AW-1:0] cfg_dx,
    input  logic [AW-1:0] cfg_dy,
    input  logic [SW-1:0] cfg_w,
    input  logic [SW-1:0] cfg_h,
    input  logic          cfg_wr,
    input  logic [AW-1:0] shift_x,
    input  logic [AW-1:0] shift_y,
    input  logic          restart,
    input  logic          adv,
    input  logic          inner_wrap,
    output logic [AW-1:0] pos_x,
    output logic [AW-1:0] pos_y,
    output logic [SW-1:0] size_w,
    output logic [SW-1:0] size_h,
    output logic          role_wr
);

    logic [AW-1:0] sx_q, sy_q, dx_q, dy_q;
    logic [SW-1:0] w_q, h_q;
    logic          wr_q;
    logic [AW-1:0] row_x_q, row_y_q;
    logic [AW-1:0] cur_x_q, cur_y_q;
    logic [AW-1:0] next_row_x, next_row_y;

    assign next_row_x = row_x_q + shift_x;
    assign next_row_y = row_y_q + shift_y;

    assign pos_x   = cur_x_q;
    assign pos_y   = cur_y_q;
    assign size_w  = w_q;
    assign size_h  = h_q;
    assign role_wr = wr_q;

    // Hold this window's configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sx_q <= '0;
            sy_q <= '0;
            dx_q <= '0;
            dy_q <= '0;
            w_q  <= '0;
            h_q  <= '0;
            wr_q <= 1'b0;
        end else if (cfg_take) begin
            sx_q <= cfg_sx;
            sy_q <= cfg_sy;
            dx_q <= cfg_dx;
            dy_q <= cfg_dy;
            w_q  <= cfg_w;
            h_q  <= cfg_h;
            wr_q <= cfg_wr;
        end
    end

    // Track the pass origin and the current base address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_x_q <= '0;
            row_y_q <= '0;
            cur_x_q <= '0;
            cur_y_q <= '0;
        end else if (restart) begin
            row_x_q <= sx_q;
            row_y_q <= sy_q;
            cur_x_q <= sx_q;
            cur_y_q <= sy_q;
        end else if (adv) begin
            if (inner_wrap) begin
                row_x_q <= next_row_x;
                row_y_q <= next_row_y;
                cur_x_q <= next_row_x;
                cur_y_q <= next_row_y;
            end else begin
                cur_x_q <= cur_x_q + dx_q;
                cur_y_q <= cur_y_q + dy_q;
            end
        end
    end

endmodule

// File: rtl/compound_scan_seq.sv
// Module: compound_scan_seq (top)
// Does: runs NUM_WIN scan windows in lockstep under one two-level loop; the
//       outer loop shifts the inner pattern by a shared vector after each pass.
// Assumes: 1 <= NUM_WIN <= scan_seq_pkg::MAX_WINDOWS; buses are packed per
//          window, window w at [w*AW +: AW] (or [w*SW +: SW]).
module compound_scan_seq
    import scan_seq_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int AW      = 8,
    parameter int SW      = 4,
    parameter int CW      = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_load,
    input  logic [NUM_WIN*AW-1:0] cfg_start_x,
    input  logic [NUM_WIN*AW-1:0] cfg_start_y,
    input  logic [NUM_WIN*AW-1:0] cfg_step_x,
    input  logic [NUM_WIN*AW-1:0] cfg_step_y,
    input  logic [NUM_WIN*SW-1:0] cfg_win_w,
    input  logic [NUM_WIN*SW-1:0] cfg_win_h,
    input  logic [NUM_WIN-1:0]    cfg_win_wr,
    input  logic [CW-1:0]         cfg_inner_cnt,
    input  logic [CW-1:0]         cfg_outer_cnt,
    input  logic [AW-1:0]         cfg_shift_x,
    input  logic [AW-1:0]         cfg_shift_y,
    input  logic                  start,
    input  logic                  stall,
    output logic [NUM_WIN*AW-1:0] win_x,
    output logic [NUM_WIN*AW-1:0] win_y,
    output logic [NUM_WIN*SW-1:0] win_w,
    output logic [NUM_WIN*SW-1:0] win_h,
    output logic [NUM_WIN-1:0]    win_wr,
    output logic                  valid,
    output logic                  busy,
    output logic                  done
);

    localparam int WIN_USED = (NUM_WIN > MAX_WINDOWS) ? MAX_WINDOWS : NUM_WIN;

    logic          adv, inner_wrap, restart, cfg_take;
    logic [AW-1:0] shift_x_q, shift_y_q;

    assign valid = adv;

    // Hold the outer shift vector shared by all windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_x_q <= '0;
            shift_y_q <= '0;
        end else if (cfg_take) begin
            shift_x_q <= cfg_shift_x;
            shift_y_q <= cfg_shift_y;
        end
    end

    scan_loop_ctrl #(.CW(CW)) u_loop (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_load     (cfg_load),
        .cfg_inner_cnt(cfg_inner_cnt),
        .cfg_outer_cnt(cfg_outer_cnt),
        .start        (start),
        .stall        (stall),
        .busy         (busy),
        .adv          (adv),
        .inner_wrap   (inner_wrap),
        .restart      (restart),
        .cfg_take     (cfg_take),
        .done         (done)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        if (w < WIN_USED) begin : g_on
            scan_win_unit #(.AW(AW), .SW(SW)) u_win (
                .clk       (clk),
                .rst_n     (rst_n),
                .cfg_take  (cfg_take),
                .cfg_sx    (cfg_start_x[w*AW +: AW]),
                .cfg_sy    (cfg_start_y[w*AW +: AW]),
                .cfg_dx    (cfg_step_x[w*AW +: AW]),
                .cfg_dy    (cfg_step_y[w*AW +: AW]),
                .cfg_w     (cfg_win_w[w*SW +: SW]),
                .cfg_h     (cfg_win_h[w*SW +: SW]),
                .cfg_wr    (cfg_win_wr[w]),
                .shift_x   (shift_x_q),
                .shift_y   (shift_y_q),
                .restart   (restart),
                .adv       (adv),
                .inner_wrap(inner_wrap),
                .pos_x     (win_x[w*AW +: AW]),
                .pos_y     (win_y[w*AW +: AW]),
                .size_w    (win_w[w*SW +: SW]),
                .size_h    (win_h[w*SW +: SW]),
                .role_wr   (win_wr[w])
            );
        end else begin : g_off
            assign win_x[w*AW +: AW] = '0;
            assign win_y[w*AW +: AW] = '0;
            assign win_w[w*SW +: SW] = '0;
            assign win_h[w*SW +: SW] = '0;
            assign win_wr[w]         = 1'b0;
        end
    end

endmodule

// File: rtl/scan_seq_chk.sv
// Module: scan_seq_chk
// Does: port-level temporal checks on compound_scan_seq, bound below.
// Assumes: synchronous active-low reset on rst_n.
module scan_seq_chk #(
    parameter int NUM_WIN = 3,
    parameter int AW      = 8,
    parameter int SW      = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  stall,
    input logic                  valid,
    input logic                  busy,
    input logic                  done,
    input logic [NUM_WIN*AW-1:0] win_x,
    input logic [NUM_WIN*AW-1:0] win_y,
    input logic [NUM_WIN*SW-1:0] win_w,
    input logic [NUM_WIN*SW-1:0] win_h,
    input logic [NUM_WIN-1:0]    win_wr
);

    // R2: a valid step only happens inside a scan.
    p_valid_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> busy);

    // R6: the end pulse lasts a single cycle.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the end pulse comes with the scan already over.
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !valid));

    // R7: a stalled cycle is never a valid step.
    p_stall_no_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !valid);

    // R7: a stalled cycle in a scan leaves the addresses in place.
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stall) |=> ($stable(win_x) && $stable(win_y)));

    // R9: size and role stay fixed across a scan cycle.
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(win_w) && $stable(win_h) && $stable(win_wr)));

endmodule

bind compound_scan_seq scan_seq_chk #(
    .NUM_WIN(NUM_WIN),
    .AW     (AW),
    .SW     (SW)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .stall (stall),
    .valid (valid),
    .busy  (busy),
    .done  (done),
    .win_x (win_x),
    .win_y (win_y),
    .win_w (win_w),
    .win_h (win_h),
    .win_wr(win_wr)
);

// File: tb/tb_compound_scan_seq.sv
module tb_compound_scan_seq;

    localparam int NW = 3;
    localparam int AW = 8;
    localparam int SW = 4;
    localparam int CW = 5;
    localparam int MASK = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0;
    logic [NW*AW-1:0] cfg_start_x = '0, cfg_start_y = '0, cfg_step_x = '0, cfg_step_y = '0;
    logic [NW*SW-1:0] cfg_win_w = '0, cfg_win_h = '0;
    logic [NW-1:0]    cfg_win_wr = '0;
    logic [CW-1:0]    cfg_inner_cnt = '0, cfg_outer_cnt = '0;
    logic [AW-1:0]    cfg_shift_x = '0, cfg_shift_y = '0;
    logic start = 1'b0, stall = 1'b0;
    logic [NW*AW-1:0] win_x, win_y;
    logic [NW*SW-1:0] win_w, win_h;
    logic [NW-1:0]    win_wr;
    logic valid, busy, done;

    int n_chk = 0;
    int n_bad = 0;
    int unused_seed;

    // Bench model of the loaded configuration.
    int m_sx[NW], m_sy[NW], m_dx[NW], m_dy[NW], m_w[NW], m_h[NW], m_wr[NW];
    int m_inner, m_outer, m_shx, m_shy;

    always #2 clk = ~clk;

    compound_scan_seq #(.NUM_WIN(NW), .AW(AW), .SW(SW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_start_x(cfg_start_x), .cfg_start_y(cfg_start_y),
        .cfg_step_x(cfg_step_x), .cfg_step_y(cfg_step_y),
        .cfg_win_w(cfg_win_w), .cfg_win_h(cfg_win_h), .cfg_win_wr(cfg_win_wr),
        .cfg_inner_cnt(cfg_inner_cnt), .cfg_outer_cnt(cfg_outer_cnt),
        .cfg_shift_x(cfg_shift_x), .cfg_shift_y(cfg_shift_y),
        .start(start), .stall(stall),
        .win_x(win_x), .win_y(win_y), .win_w(win_w), .win_h(win_h), .win_wr(win_wr),
        .valid(valid), .busy(busy), .done(done)
    );

    function automatic int exp_x(int w, int i, int o);
        return (m_sx[w] + o * m_shx + i * m_dx[w]) & MASK;
    endfunction

    function automatic int exp_y(int w, int i, int o);
        return (m_sy[w] + o * m_shy + i * m_dy[w]) & MASK;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    // Drive a full configuration and pulse the load strobe.
    task automatic load_cfg(int inner, int outer, int shx, int shy);
        @(negedge clk);
        for (int w = 0; w < NW; w++) begin
            cfg_start_x[w*AW +: AW] = AW'(m_sx[w]);
            cfg_start_y[w*AW +: AW] = AW'(m_sy[w]);
            cfg_step_x[w*AW +: AW]  = AW'(m_dx[w]);
            cfg_step_y[w*AW +: AW]  = AW'(m_dy[w]);
            cfg_win_w[w*SW +: SW]   = SW'(m_w[w]);
            cfg_win_h[w*SW +: SW]   = SW'(m_h[w]);
            cfg_win_wr[w]           = m_wr[w][0];
        end
        cfg_inner_cnt = CW'(inner);
        cfg_outer_cnt = CW'(outer);
        cfg_shift_x   = AW'(shx);
        cfg_shift_y   = AW'(shy);
        m_inner = (inner == 0) ? 1 : inner;
        m_outer = (outer == 0) ? 1 : outer;
        m_shx = shx;
        m_shy = shy;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic rand_windows();
        for (int w = 0; w < NW; w++) begin
            m_sx[w] = int'($urandom % 256);
            m_sy[w] = int'($urandom % 256);
            m_dx[w] = int'($urandom % 256);
            m_dy[w] = int'($urandom % 256);
            m_w[w]  = int'($urandom % 16);
            m_h[w]  = int'($urandom % 16);
            m_wr[w] = int'($urandom % 2);
        end
    endtask

    // Run one scan, checking every cycle; optionally poke load/start mid-run.
    task automatic run_scan(int stall_pct, bit poke);
        int i = 0;
        int o = 0;
        int steps = 0;
        int seen = 0;
        bit fin = 0;
        @(negedge clk);
        #1;
        check("R2 idle before start", int'(busy), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin) begin
            stall = (int'($urandom % 100) < stall_pct);
            if (poke && steps == 2) begin
                cfg_start_x = ~cfg_start_x;
                cfg_inner_cnt = ~cfg_inner_cnt;
                cfg_win_wr = ~cfg_win_wr;
                cfg_load = 1'b1;
                start = 1'b1;
            end
            #1;
            check("R2 busy during scan", int'(busy), 1);
            for (int w = 0; w < NW; w++) begin
                check("R9 width", int'(win_w[w*SW +: SW]), m_w[w]);
                check("R9 height", int'(win_h[w*SW +: SW]), m_h[w]);
                check("R9 role", int'(win_wr[w]), m_wr[w]);
            end
            if (stall) begin
                check("R7 no step on stall", int'(valid), 0);
                for (int w = 0; w < NW; w++) begin
                    check("R7 x held", int'(win_x[w*AW +: AW]), exp_x(w, i, o));
                    check("R7 y held", int'(win_y[w*AW +: AW]), exp_y(w, i, o));
                end
            end else begin
                check("R2 valid", int'(valid), 1);
                for (int w = 0; w < NW; w++) begin
                    check("R3 x", int'(win_x[w*AW +: AW]), exp_x(w, i, o));
                    check("R3 y", int'(win_y[w*AW +: AW]), exp_y(w, i, o));
                end
                seen++;
                steps++;
                if (i == m_inner - 1) begin
                    i = 0;
                    if (o == m_outer - 1) fin = 1;
                    else o++;
                end else begin
                    i++;
                end
                check("R6 no early done", int'(done), 0);
            end
            @(negedge clk);
            cfg_load = 1'b0;
            start = 1'b0;
        end
        stall = 1'b0;
        #1;
        check("R5 step count", seen, m_inner * m_outer);
        check("R6 done pulse", int'(done), 1);
        check("R6 idle at done", int'(busy), 0);
        check("R6 no valid at done", int'(valid), 0);
        @(negedge clk);
        #1;
        check("R6 done one cycle", int'(done), 0);
    endtask

    initial begin
        unused_seed = $urandom(32'h5EED_C0DE);
        repeat (3) @(negedge clk);
        #1;
        check("R1 valid after reset", int'(valid), 0);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 done after reset", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed: one 2x2 read window, two 1x1 write windows, 8 steps, +2 x shift.
        m_sx = '{0, 4, 8};  m_sy = '{0, 0, 0};
        m_dx = '{0, 0, 0};  m_dy = '{1, 1, 1};
        m_w  = '{2, 1, 1};  m_h  = '{2, 1, 1};
        m_wr = '{0, 1, 1};
        load_cfg(8, 3, 2, 0);
        run_scan(0, 0);
        run_scan(30, 1);
        // R8: the scan after the poke still follows the old configuration.
        run_scan(0, 0);

        // R8: load and start in the same idle cycle -> load only.
        rand_windows();
        @(negedge clk);
        for (int w = 0; w < NW; w++) begin
            cfg_win_w[w*SW +: SW] = SW'(m_w[w]);
            cfg_win_h[w*SW +: SW] = SW'(m_h[w]);
            cfg_win_wr[w]         = m_wr[w][0];
        end
        cfg_load = 1'b1;
        start = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        start = 1'b0;
        #1;
        check("R8 start ignored with load", int'(busy), 0);
        check("R8 load taken width", int'(win_w[0 +: SW]), m_w[0]);

        // R4/R5 corners: single step, and zero counts acting as one.
        load_cfg(1, 1, 5, 7);
        run_scan(0, 0);
        load_cfg(0, 0, 1, 1);
        run_scan(20, 0);
        // R3: negative steps and shifts wrap.
        m_dx = '{255, 254, 1};
        m_dy = '{0, 253, 128};
        load_cfg(4, 5, 250, 3);
        run_scan(10, 0);

        // Random configurations with random stalls.
        for (int r = 0; r < 8; r++) begin
            rand_windows();
            load_cfg(int'($urandom % 32), int'($urandom % 8), int'($urandom % 256),
                     int'($urandom % 256));
            run_scan(int'($urandom % 50), (r % 3) == 0);
        end

        finish_run();
    end

endmodule